// File: doc/BRIEF.md
# Burst-of-Four Pipelined Read Port

This block is the read half of a synchronous SRAM with a dedicated read port. Each array address names one 72-bit line. The line is handed out as four 18-bit words on four consecutive half-cycle edges. Both edges of the input clock are modelled as alternating phases of one fast clock. A phase bit starts at the rising phase on the first edge after reset, and it toggles on every edge after that.

The active-low read select and the address are sampled only on rising-phase edges. After a request is accepted, the next rising-phase edge belongs to the running burst, so a request there is dropped. Requests placed on every other rising phase form a continuous stream of words. Once the last pending word has been sent, the output enable falls at the next rising phase and the data bus reads zero.

A plain full-line load port fills the array. It stands in for the write side, which lies outside this block.

Top module: `qburst_rd`

## Requirements
- R1: While reset is asserted, and before the first read, `rd_oe` is 0 and `rd_q` is 0. The first clock edge after reset release is a rising-phase edge, and edges alternate rising/falling after it.
- R2: `rd_n` low is only acted on at rising-phase edges. A request presented at a falling-phase edge produces no output.
- R3: For a request accepted at rising-phase edge E, `rd_oe` goes high after edge E+2. `rd_q` then carries line bits [17:0], and `rd_beat` is 0.
- R4: After edges E+3, E+4 and E+5, `rd_q` carries line bits [35:18], [53:36] and [71:54], and `rd_beat` is 1, 2 and 3.
- R5: A request at the rising-phase edge directly after an accepted request is dropped. Its address is never read, and it adds no words to the output.
- R6: Requests every fourth edge, that is every other rising phase, keep `rd_oe` high with no gap. Each one delivers its four words in order.
- R7: When no further burst is pending, `rd_oe` falls and `rd_q` returns to 0 after the rising-phase edge that follows the last word.
- R8: With `ld_en` high, `ld_data` is written at a clock edge to line `ld_addr`. Later reads of that line return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each edge stands for one half-cycle of the input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Line load enable |
| ld_addr | input | AW | Line address to load |
| ld_data | input | 4*WW | Full 72-bit line to store |
| rd_n | input | 1 | Active-low read select |
| rd_addr | input | AW | Read line address |
| rd_q | output | WW | Read word; zero while not driven |
| rd_oe | output | 1 | Output enable, high while a word is valid |
| rd_beat | output | 2 | Index of the word currently on `rd_q` |

## Verification
The hardest situation to reach from the ports is a dropped request that falls exactly on the rising phase after an accepted one, while the previous burst is still draining. To produce it, the stimulus must track the phase and place requests at the right edges. The bench counts edges from reset release and aligns directed sequences to rising phases. The sequences cover a dropped second request, a request on a falling phase, and a full-rate stream. Random `rd_n` activity on all edges is then checked against a bench-side schedule of expected words.

// File: rtl/qburst_rd.sv
module qburst_rd #(
  parameter int AW = 6,
  parameter int WW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [4*WW-1:0] ld_data,
  input  logic            rd_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [WW-1:0]   rd_q,
  output logic            rd_oe,
  output logic [1:0]      rd_beat
);
  localparam int LW    = 4 * WW;
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];
  logic          ph;
  logic          acc;
  logic [AW-1:0] raddr;
  logic [LW-1:0] line;
  logic [1:0]    beat;
  logic          oe;

  wire take   = !ph && !rd_n && !acc;
  wire launch = !ph && acc;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph    <= 1'b0;
      acc   <= 1'b0;
      raddr <= '0;
    end else begin
      ph <= ~ph;
      if (!ph) acc <= take;
      if (take) raddr <= rd_addr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line <= '0;
      beat <= 2'd0;
      oe   <= 1'b0;
    end else if (launch) begin
      line <= mem[raddr];
      beat <= 2'd0;
      oe   <= 1'b1;
    end else if (oe && beat != 2'd3) begin
      beat <= beat + 2'd1;
    end else begin
      oe <= 1'b0;
    end

  assign rd_q    = oe ? line[32'(beat)*WW +: WW] : '0;
  assign rd_oe   = oe;
  assign rd_beat = beat;
endmodule

module qburst_rd_chk #(
  parameter int WW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph,
  input logic          acc,
  input logic          oe,
  input logic [1:0]    beat,
  input logic [WW-1:0] rd_q
);
  a_r2_accept_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc) |-> ph);

  a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph && acc) |=> (oe && beat == 2'd0));

  a_r4_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && beat != 2'd3) |=> (oe && beat == $past(beat) + 2'd1));

  a_r5_drop_next_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph && acc) |=> !acc);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && beat == 2'd3 && !acc) |=> (!oe && rd_q == '0));
endmodule

bind qburst_rd qburst_rd_chk #(.WW(WW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ph(ph), .acc(acc),
  .oe(oe), .beat(beat), .rd_q(rd_q)
);

// File: tb/qburst_rd_tb.sv
module qburst_rd_tb_top;
  localparam int AW = 6;
  localparam int WW = 18;
  localparam int LW = 4 * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [LW-1:0] ld_data = '0;
  logic rd_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [WW-1:0] rd_q;
  logic rd_oe;
  logic [1:0] rd_beat;

  int checks = 0, errors = 0, e = 0, last_acc = -10, oe_hi = 0, drops = 0;
  bit done = 0;
  logic [LW-1:0] ref_mem [1<<AW];
  logic          exp_v [8];
  logic [WW-1:0] exp_d [8];
  logic [1:0]    exp_b [8];

  always #10 clk = ~clk;

  qburst_rd #(.AW(AW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_n(rd_n), .rd_addr(rd_addr), .rd_q(rd_q), .rd_oe(rd_oe), .rd_beat(rd_beat));

  function automatic logic [WW-1:0] word_of(logic [LW-1:0] l, int k);
    return l[k*WW +: WW];
  endfunction

  task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (edge %0d)", req, act, expv, e);
    end
  endtask

  task automatic step(input logic rn, input logic [AW-1:0] a);
    rd_n = rn; rd_addr = a;
    @(posedge clk);
    if (ld_en) ref_mem[ld_addr] = ld_data;
    if (e % 2 == 0 && !rn) begin
      if (last_acc == e - 2) drops++;
      else begin
        last_acc = e;
        for (int k = 0; k < 4; k++) begin
          exp_v[(e+2+k)%8] = 1'b1;
          exp_d[(e+2+k)%8] = word_of(ref_mem[a], k);
          exp_b[(e+2+k)%8] = 2'(k);
        end
      end
    end
    @(negedge clk);
    chk("R3/R7 oe", LW'(rd_oe), LW'(exp_v[e%8]));
    chk("R4 data", LW'(rd_q), exp_v[e%8] ? LW'(exp_d[e%8]) : '0);
    if (exp_v[e%8]) chk("R4 beat", LW'(rd_beat), LW'(exp_b[e%8]));
    if (rd_oe) oe_hi++;
    exp_v[e%8] = 1'b0;
    e++;
  endtask

  task automatic align();
    if (e % 2 != 0) step(1'b1, '0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, '0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) exp_v[i] = 1'b0;
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", LW'(rd_oe), '0);
    chk("R1 q in reset", LW'(rd_q), '0);
    rst_n = 1'b1;
    // R8: preload every line through the load port
    ld_en = 1'b1;
    for (int i = 0; i < (1<<AW); i++) begin
      ld_addr = AW'(i);
      ld_data = {$urandom, $urandom, $urandom};
      step(1'b1, '0);
    end
    ld_en = 1'b0;
    idle(2);
    // R3 R4 R7: single read
    align(); oe_hi = 0;
    step(1'b0, 6'd5); idle(8);
    chk("R7 single burst length", LW'(oe_hi), LW'(4));
    // R5: request on the next rise is dropped
    align(); oe_hi = 0; drops = 0;
    step(1'b0, 6'd9); step(1'b1, '0); step(1'b0, 6'd33); idle(8);
    chk("R5 dropped words", LW'(oe_hi), LW'(4));
    chk("R5 drop seen", LW'(drops), LW'(1));
    // R2: request on a falling phase ignored
    align(); oe_hi = 0;
    step(1'b1, '0); step(1'b0, 6'd12); step(1'b1, '0); idle(6);
    chk("R2 falling phase ignored", LW'(oe_hi), '0);
    // R6: full-rate stream
    align(); oe_hi = 0;
    for (int i = 0; i < 20; i++) step((i % 4 == 0) ? 1'b0 : 1'b1, AW'(i * 3 + 1));
    idle(6);
    chk("R6 gap-free stream", LW'(oe_hi), LW'(20));
    // Random phase-mixed requests
    for (int i = 0; i < 800; i++) step(1'(($urandom % 2)), AW'($urandom));
    idle(8);
    chk("R7 idle at end", LW'(rd_oe), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule